// File: doc/BRIEF.md
# Gated Up/Down Edge Counter

This block counts rising edges of an asynchronous measured signal in a 32-bit register that wraps in both directions. A level-sensitive pause input stops counting while it sits at a programmable active level. The count direction is fixed up, fixed down, or follows an external direction pin.

Every asynchronous input is brought into the system clock domain through a two-flop synchronizer and then edge-detected. The running count can be published in three ways. In single mode, a readable holding register is refreshed on every measured rising edge. In explicit-sample mode, a valid/data stream carries one sample per rising edge of a separate sample clock. In implicit-sample mode, the stream carries one sample per rising edge of the measured signal.

A one-cycle arm pulse loads a programmable start value into the count and the holding register. It also clears the stream and its overrun flag. The block has no memory, no pin routing and no bus interface.

Top module: `edge_tally`

## Requirements
- R1: After reset the count, holding register, sample data, sample valid and overrun are all zero.
- R2: With direction code 0 (up), each unpaused rising edge of `sig_in` adds one to the count, wrapping from 0xFFFFFFFF to 0. The new value is visible at `cnt_value` no later than four clock cycles after the edge.
- R3: With direction code 1 (down), each unpaused rising edge subtracts one, wrapping from 0 to 0xFFFFFFFF.
- R4: With direction code 2 (external), the count goes up on an edge while `dir_in` is high and down while it is low.
- R5: While the synchronized `pause_in` equals `cfg_pause_pol`, rising edges leave the count unchanged. With the opposite level they count normally.
- R6: In mode code 0 (single), `hold_value` takes the post-edge count on every rising edge of `sig_in`, and the stream stays idle.
- R7: In mode code 1 (explicit), each rising edge of `sclk_in` emits one sample holding the current count. Edges of `sig_in` emit nothing.
- R8: In mode code 2 (implicit), each rising edge of `sig_in` emits one sample holding the count after that edge is applied.
- R9: A pending sample keeps `smp_valid` high and its data until `smp_ready` is high. A new sample that arrives while one is still pending replaces it.
- R10: `overrun` sets when a sample arrives while the previous one is pending, and it stays set until the next arm.
- R11: A one-cycle `arm` loads `cfg_init` into the count and `hold_value`, and clears `smp_valid` and `overrun`. Arm takes priority over a simultaneous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse: load start value, clear stream state |
| cfg_mode | input | 2 | 0 single, 1 explicit sample clock, 2 implicit sample clock |
| cfg_dir | input | 2 | 0 up, 1 down, 2 external pin |
| cfg_pause_pol | input | 1 | Pause level that stops counting |
| cfg_init | input | 32 | Start value loaded on arm |
| sig_in | input | 1 | Measured signal (asynchronous) |
| pause_in | input | 1 | Pause gate (asynchronous) |
| dir_in | input | 1 | External direction, high = up (asynchronous) |
| sclk_in | input | 1 | Explicit sample clock (asynchronous) |
| smp_ready | input | 1 | Stream consumer ready |
| cnt_value | output | 32 | Live count |
| hold_value | output | 32 | Single-mode holding register |
| smp_valid | output | 1 | Stream sample pending |
| smp_data | output | 32 | Stream sample value |
| overrun | output | 1 | Sticky sample-overrun flag |

## Verification
The in-line assertions watch, on every cycle, that the count holds still without an edge or arm and holds still under pause. They also check that an unpaused up-edge adds exactly one, that a detected edge is never two cycles long, that a pending sample is not dropped before it is accepted, and that overrun never clears without an arm. Only the bench scenarios can show that the count reaches the right value after a train of edges in each direction, and that the wrap boundaries are crossed correctly. The same holds for the pause polarity choice, the sample values in each mode, the replacement of an unread sample, and the arm priority.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_EXPLICIT = 2'd1,
    MODE_IMPLICIT = 2'd2
  } tally_mode_e;

  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_EXT  = 2'd2
  } tally_dir_e;

  // bit positions in the synchronized input vector
  localparam int IDX_SIG   = 0;
  localparam int IDX_PAUSE = 1;
  localparam int IDX_DIR   = 2;
  localparam int IDX_SCLK  = 3;
  localparam int N_ASYNC   = 4;
endpackage

// File: rtl/tally_sync.sv
module tally_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], din[i]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~prev;

    // R2
    no_double_rise_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/tally_core.sv
module tally_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic [W-1:0] init,
  input  logic         edge_seen,
  input  logic         paused,
  input  logic         up,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next
);
  logic step;
  assign step = edge_seen & ~paused;

  always_comb begin
    if (arm)       count_next = init;
    else if (step) count_next = up ? count + 1'b1 : count - 1'b1;
    else           count_next = count;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_next;
  end

  // R11
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !arm && !edge_seen |=> $stable(count));
  // R5
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !arm && edge_seen && paused |=> $stable(count));
  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    !arm && edge_seen && !paused && up |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/tally_sampler.sv
module tally_sampler
  import edge_tally_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  tally_mode_e  mode,
  input  logic         sig_rise,
  input  logic         sclk_rise,
  input  logic [W-1:0] value,
  input  logic         ready,
  output logic [W-1:0] hold,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovr
);
  logic fire;
  assign fire = !arm && ((mode == MODE_EXPLICIT && sclk_rise) ||
                         (mode == MODE_IMPLICIT && sig_rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (arm) begin
      hold <= value;
    end else if (mode == MODE_SINGLE && sig_rise) begin
      hold <= value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      ovr   <= 1'b0;
    end else if (arm) begin
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else if (fire) begin
      valid <= 1'b1;
      data  <= value;
      if (valid && !ready) ovr <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R9
  pending_kept_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !ready && !arm |=> valid);
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovr && !arm |=> ovr);
  // R6
  single_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_SINGLE && !valid |=> !valid);
endmodule

// File: rtl/edge_tally.sv
module edge_tally
  import edge_tally_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_dir,
  input  logic          cfg_pause_pol,
  input  logic [CW-1:0] cfg_init,
  input  logic          sig_in,
  input  logic          pause_in,
  input  logic          dir_in,
  input  logic          sclk_in,
  input  logic          smp_ready,
  output logic [CW-1:0] cnt_value,
  output logic [CW-1:0] hold_value,
  output logic          smp_valid,
  output logic [CW-1:0] smp_data,
  output logic          overrun
);
  logic [N_ASYNC-1:0] raw, lvl, rse;
  logic [CW-1:0]      count_next;
  logic               paused, up;
  tally_mode_e        mode;

  always_comb begin
    raw            = '0;
    raw[IDX_SIG]   = sig_in;
    raw[IDX_PAUSE] = pause_in;
    raw[IDX_DIR]   = dir_in;
    raw[IDX_SCLK]  = sclk_in;
  end

  tally_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .level(lvl), .rise(rse)
  );

  assign paused = (lvl[IDX_PAUSE] == cfg_pause_pol);
  assign mode   = tally_mode_e'(cfg_mode);

  always_comb begin
    case (tally_dir_e'(cfg_dir))
      DIR_DOWN: up = 1'b0;
      DIR_EXT:  up = lvl[IDX_DIR];
      default:  up = 1'b1;
    endcase
  end

  tally_core #(.W(CW)) u_core (
    .clk(clk), .rst(rst), .arm(arm), .init(cfg_init),
    .edge_seen(rse[IDX_SIG]), .paused(paused), .up(up),
    .count(cnt_value), .count_next(count_next)
  );

  tally_sampler #(.W(CW)) u_smp (
    .clk(clk), .rst(rst), .arm(arm), .mode(mode),
    .sig_rise(rse[IDX_SIG]), .sclk_rise(rse[IDX_SCLK]),
    .value(count_next), .ready(smp_ready),
    .hold(hold_value), .valid(smp_valid), .data(smp_data), .ovr(overrun)
  );
endmodule

// File: tb/sim_edge_tally.sv
module sim_edge_tally;
  logic        clk = 0, rst = 1, arm = 0;
  logic [1:0]  cfg_mode = 0, cfg_dir = 0;
  logic        cfg_pause_pol = 1;
  logic [31:0] cfg_init = 0;
  logic        sig_in = 0, pause_in = 0, dir_in = 0, sclk_in = 0, smp_ready = 1;
  logic [31:0] cnt_value, hold_value, smp_data;
  logic        smp_valid, overrun;

  int tests = 0, fails = 0, nsmp = 0;
  logic [31:0] last_smp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_tally u0 (.*);

  // count accepted samples between clock edges
  always @(negedge clk) if (!rst && smp_valid && smp_ready) begin
    nsmp++; last_smp = smp_data;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sig(int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1; cyc(4); sig_in = 0; cyc(4);
    end
  endtask

  task automatic pulse_sclk(int n);
    for (int i = 0; i < n; i++) begin
      sclk_in = 1; cyc(4); sclk_in = 0; cyc(4);
    end
  endtask

  task automatic do_arm(logic [31:0] v);
    cfg_init = v; arm = 1; cyc(1); arm = 0; cyc(1);
  endtask

  task automatic t_reset;
    chk("R1 count", cnt_value, 0);
    chk("R1 hold", hold_value, 0);
    chk("R1 data", smp_data, 0);
    chk("R1 valid", {31'b0, smp_valid}, 0);
    chk("R1 overrun", {31'b0, overrun}, 0);
  endtask

  task automatic t_up_down;
    cfg_mode = 0; cfg_dir = 0; do_arm(32'd10);
    chk("R11 arm load", cnt_value, 10);
    pulse_sig(5);
    chk("R2 up count", cnt_value, 15);
    chk("R6 hold", hold_value, 15);
    chk("R6 no stream", nsmp, 0);
    cfg_dir = 1; pulse_sig(3);
    chk("R3 down count", cnt_value, 12);
    do_arm(0); pulse_sig(1);
    chk("R3 wrap down", cnt_value, 32'hFFFFFFFF);
    cfg_dir = 0; pulse_sig(1);
    chk("R2 wrap up", cnt_value, 0);
  endtask

  task automatic t_external;
    cfg_mode = 0; cfg_dir = 2; do_arm(100);
    dir_in = 1; cyc(4); pulse_sig(4);
    chk("R4 ext up", cnt_value, 104);
    dir_in = 0; cyc(4); pulse_sig(6);
    chk("R4 ext down", cnt_value, 98);
  endtask

  task automatic t_pause;
    cfg_mode = 0; cfg_dir = 0; do_arm(50);
    cfg_pause_pol = 1; pause_in = 1; cyc(4); pulse_sig(3);
    chk("R5 paused high", cnt_value, 50);
    chk("R6 hold while paused", hold_value, 50);
    cfg_pause_pol = 0; pulse_sig(2);
    chk("R5 opposite level counts", cnt_value, 52);
    pause_in = 0; cyc(4); pulse_sig(2);
    chk("R5 paused low", cnt_value, 52);
    cfg_pause_pol = 1; pulse_sig(1);
    chk("R5 resume", cnt_value, 53);
  endtask

  task automatic t_explicit;
    cfg_mode = 1; cfg_dir = 0; smp_ready = 1; do_arm(200); nsmp = 0;
    pulse_sig(3);
    chk("R7 no sample on sig", nsmp, 0);
    pulse_sclk(1);
    chk("R7 one sample", nsmp, 1);
    chk("R7 sample value", last_smp, 203);
    pulse_sig(2); pulse_sclk(2);
    chk("R7 count samples", nsmp, 3);
    chk("R7 later value", last_smp, 205);
  endtask

  task automatic t_implicit;
    cfg_mode = 2; cfg_dir = 1; smp_ready = 1; do_arm(7); nsmp = 0;
    pulse_sig(4);
    chk("R8 sample count", nsmp, 4);
    chk("R8 post-edge value", last_smp, 3);
    pulse_sclk(2);
    chk("R8 sclk ignored", nsmp, 4);
  endtask

  task automatic t_overrun;
    cfg_mode = 1; cfg_dir = 0; do_arm(40); smp_ready = 0; nsmp = 0;
    pulse_sig(1); pulse_sclk(1);
    chk("R9 held valid", {31'b0, smp_valid}, 1);
    chk("R10 no overrun yet", {31'b0, overrun}, 0);
    pulse_sig(1); pulse_sclk(1);
    chk("R10 overrun set", {31'b0, overrun}, 1);
    chk("R9 replaced data", smp_data, 42);
    smp_ready = 1; cyc(2);
    chk("R9 accepted", {31'b0, smp_valid}, 0);
    chk("R10 sticky", {31'b0, overrun}, 1);
    do_arm(9);
    chk("R11 overrun cleared", {31'b0, overrun}, 0);
    chk("R11 hold loaded", hold_value, 9);
  endtask

  task automatic t_arm_priority;
    cfg_mode = 0; cfg_dir = 0; do_arm(300);
    sig_in = 1; cyc(2);
    // edge reaches the core on the next posedge; arm it in the same cycle
    cfg_init = 77; arm = 1; cyc(1); arm = 0; cyc(3);
    sig_in = 0; cyc(4);
    chk("R11 arm beats edge", cnt_value, 77);
  endtask

  initial begin
    cyc(3); rst = 0; cyc(2);
    t_reset;
    t_up_down;
    t_external;
    t_pause;
    t_explicit;
    t_implicit;
    t_overrun;
    t_arm_priority;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule